// File: doc/BRIEF.md
# Sixteen-Channel Clock Selector, Divider and Gate Bank

This block drives up to sixteen output clocks from a shared set of four source clocks. Each channel picks one source, divides it by 1, 2, 4 or 8, and can be stopped. Three 32-bit registers hold the settings for all channels: a stop register with one bit per channel, a source-select register with a 2-bit field per channel, and a divide register with a 2-bit field per channel. All three sit on a simple word bus with a byte address, a write strobe and a combinational read port.

The block works in a single fast clock domain `clk`. The four sources arrive on `src_i` as level waveforms that change in step with `clk` and are much slower than it, with a 50% duty cycle. Every output is a register, so each channel output is a clean, retimed clock. Settings are never applied in the middle of a high phase. A running channel picks up new settings, including a stop request, only at the moment its output falls. A stopped channel follows the registers at once and starts again from a low output.

Top module: `clk_channel_bank`

## Requirements
- R1: The stop register is at byte address 0x0, the source-select register at 0x4 and the divide register at 0x8. A write with `bus_wr_en` high updates the addressed register at the clock edge. `bus_rdata` shows the addressed register in the same cycle. Any other address reads as zero, and a write to it changes no register.
- R2: After reset the stop register holds a one for every channel (0x0000FFFF with 16 channels). The select and divide registers hold zero, and every `clk_o` bit is low.
- R3: Bit i of the stop register at 1 stops channel i, and at 0 lets it run. A running channel that is asked to stop finishes its current high phase and then stays low. A stopped channel that is released starts from low, and its first high phase has full length.
- R4: Bits [2i+1:2i] of the source-select register hold a value k that makes channel i derive its output from `src_i[k]`.
- R5: Bits [2i+1:2i] of the divide register hold a value v. In steady state both the high and the low phase of channel i then last 2^v half-periods of the selected source, which gives an output period 2^v times the source period.
- R6: A change of a running channel's select or divide field does not alter a high phase already in progress. The new settings apply from the next falling edge of that output.
- R7: An output changes level exactly one `clk` cycle after a level change of its selected source is presented on `src_i`, never in the same cycle.
- R8: Stop-register bits at and above the channel count (bits 31:16 with 16 channels) read as zero, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock that samples sources and retimes outputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Byte address of the register access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| src_i | input | 4 | The four source clock waveforms |
| clk_o | output | 16 | One output clock per channel |

## Verification
The assertions check on every cycle the following:
- an output is never high while its channel is stopped;
- a channel's applied settings hold still across every high cycle;
- an output never moves without a source change in the cycle before;
- unmapped addresses read zero;
- stop-register writes land.

Only the bench scenarios can show that the phase lengths match 2^v times the half-period of the chosen source. The same holds for three timing behaviours:
- a stop request lets the high phase in progress finish;
- a mid-phase divide or select change applies from the next fall;
- each output toggles exactly one cycle after its source.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;

  localparam int unsigned REG_W = 32;

  localparam logic [7:0] OFS_STOP = 8'h00;
  localparam logic [7:0] OFS_SEL  = 8'h04;
  localparam logic [7:0] OFS_DIV  = 8'h08;

  typedef enum logic [1:0] {
    SLOT_NONE,
    SLOT_STOP,
    SLOT_SEL,
    SLOT_DIV
  } reg_slot_e;

  function automatic reg_slot_e slot_of(input logic [7:0] byte_addr);
    reg_slot_e s;
    case (byte_addr)
      OFS_STOP: s = SLOT_STOP;
      OFS_SEL:  s = SLOT_SEL;
      OFS_DIV:  s = SLOT_DIV;
      default:  s = SLOT_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/clkbank_rst_sync.sv
module clkbank_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/clkbank_regs.sv
module clkbank_regs
  import clkbank_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned DIV_W  = 2,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      wr_en,
  input  logic [REG_W-1:0]          wdata,
  output logic [REG_W-1:0]          rdata,
  output logic [NUM_CH-1:0]         stop_q,
  output logic [NUM_CH*SEL_W-1:0]   sel_q,
  output logic [NUM_CH*DIV_W-1:0]   div_q
);

  localparam int unsigned SEL_BITS = NUM_CH * SEL_W;
  localparam int unsigned DIV_BITS = NUM_CH * DIV_W;

  reg_slot_e slot;

  logic                stop_en, sel_en, div_en;
  logic [NUM_CH-1:0]   stop_d;
  logic [SEL_BITS-1:0] sel_d;
  logic [DIV_BITS-1:0] div_d;

  always_comb begin
    slot = slot_of(8'(addr));
  end

  // next-state and clock enables
  always_comb begin
    stop_en = wr_en && (slot == SLOT_STOP);
    sel_en  = wr_en && (slot == SLOT_SEL);
    div_en  = wr_en && (slot == SLOT_DIV);
    stop_d  = wdata[NUM_CH-1:0];
    sel_d   = wdata[SEL_BITS-1:0];
    div_d   = wdata[DIV_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= '1;
    end else if (stop_en) begin
      stop_q <= stop_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (div_en) begin
      div_q <= div_d;
    end
  end

  // read port
  always_comb begin
    case (slot)
      SLOT_STOP: rdata = REG_W'(stop_q);
      SLOT_SEL:  rdata = REG_W'(sel_q);
      SLOT_DIV:  rdata = REG_W'(div_q);
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/clkbank_chan.sv
module clkbank_chan #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned DIV_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [(1<<SEL_W)-1:0]  src_now,
  input  logic [(1<<SEL_W)-1:0]  src_prev,
  input  logic [SEL_W-1:0]       sel_cfg,
  input  logic [DIV_W-1:0]       div_cfg,
  input  logic                   stop_cfg,
  output logic                   clk_o,
  output logic [SEL_W-1:0]       sel_act,
  output logic [DIV_W-1:0]       div_act,
  output logic                   stopped
);

  // largest exponent is 2^DIV_W-1, so the edge counter needs that many bits
  localparam int unsigned CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;
  logic [SEL_W-1:0] sel_d;
  logic [DIV_W-1:0] div_d;
  logic             stop_d;
  logic             en;

  logic [CNT_W-1:0] cnt_last;
  logic             src_edge;
  logic             at_last;
  logic             fall_now;
  logic             boundary;

  always_comb begin
    cnt_last = CNT_W'((32'd1 << div_act) - 32'd1);
    src_edge = src_now[sel_act] ^ src_prev[sel_act];
    at_last  = (cnt_q == cnt_last);
    fall_now = !stopped && out_q && src_edge && at_last;
    // settings are adopted only while the output is (about to be) low
    boundary = stopped || fall_now;
    en       = boundary || src_edge;
  end

  always_comb begin
    cnt_d  = cnt_q;
    out_d  = out_q;
    sel_d  = sel_act;
    div_d  = div_act;
    stop_d = stopped;
    if (boundary) begin
      sel_d  = sel_cfg;
      div_d  = div_cfg;
      stop_d = stop_cfg;
      cnt_d  = '0;
      out_d  = 1'b0;
    end else if (src_edge) begin
      if (at_last) begin
        out_d = ~out_q;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      out_q   <= 1'b0;
      sel_act <= '0;
      div_act <= '0;
      stopped <= 1'b1;
    end else if (en) begin
      cnt_q   <= cnt_d;
      out_q   <= out_d;
      sel_act <= sel_d;
      div_act <= div_d;
      stopped <= stop_d;
    end
  end

  assign clk_o = out_q;

endmodule

// File: rtl/clk_channel_bank.sv
module clk_channel_bank
  import clkbank_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned DIV_W  = 2,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wr_en,
  input  logic [REG_W-1:0]       bus_wdata,
  output logic [REG_W-1:0]       bus_rdata,
  input  logic [(1<<SEL_W)-1:0]  src_i,
  output logic [NUM_CH-1:0]      clk_o
);

  localparam int unsigned NUM_SRC = 1 << SEL_W;

  logic                      rst_sync_n;
  logic [NUM_SRC-1:0]        src_q;
  logic [NUM_CH-1:0]         stop_q;
  logic [NUM_CH*SEL_W-1:0]   sel_q;
  logic [NUM_CH*DIV_W-1:0]   div_q;
  logic [NUM_CH*SEL_W-1:0]   sel_act_v;
  logic [NUM_CH*DIV_W-1:0]   div_act_v;
  logic [NUM_CH-1:0]         stopped_v;

  clkbank_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // one-cycle history of the sources, shared by every channel's edge detector
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      src_q <= '0;
    end else begin
      src_q <= src_i;
    end
  end

  clkbank_regs #(
    .NUM_CH (NUM_CH),
    .SEL_W  (SEL_W),
    .DIV_W  (DIV_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .addr   (bus_addr),
    .wr_en  (bus_wr_en),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .stop_q (stop_q),
    .sel_q  (sel_q),
    .div_q  (div_q)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    clkbank_chan #(
      .SEL_W (SEL_W),
      .DIV_W (DIV_W)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .src_now  (src_i),
      .src_prev (src_q),
      .sel_cfg  (sel_q[ch*SEL_W +: SEL_W]),
      .div_cfg  (div_q[ch*DIV_W +: DIV_W]),
      .stop_cfg (stop_q[ch]),
      .clk_o    (clk_o[ch]),
      .sel_act  (sel_act_v[ch*SEL_W +: SEL_W]),
      .div_act  (div_act_v[ch*DIV_W +: DIV_W]),
      .stopped  (stopped_v[ch])
    );
  end

endmodule

// File: rtl/clkbank_chk.sv
module clkbank_chk #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned DIV_W  = 2,
  parameter int unsigned ADDR_W = 4
) (
  input logic                    clk,
  input logic                    rst_ni,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic                    bus_wr_en,
  input logic [31:0]             bus_wdata,
  input logic [31:0]             bus_rdata,
  input logic [(1<<SEL_W)-1:0]   src_i,
  input logic [(1<<SEL_W)-1:0]   src_q,
  input logic [NUM_CH-1:0]       stop_q,
  input logic [NUM_CH-1:0]       clk_o,
  input logic [NUM_CH-1:0]       stopped_v,
  input logic [NUM_CH*SEL_W-1:0] sel_act_v,
  input logic [NUM_CH*DIV_W-1:0] div_act_v
);

  logic [7:0] a8;
  logic       mapped;

  always_comb begin
    a8     = 8'(bus_addr);
    mapped = (a8 == 8'h00) || (a8 == 8'h04) || (a8 == 8'h08);
  end

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    !mapped |-> (bus_rdata == 32'd0)); // R1

  AST_STOP_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr_en && a8 == 8'h00) |=> (stop_q == $past(bus_wdata[NUM_CH-1:0]))); // R1

  AST_STOP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    (a8 == 8'h00) |-> ((bus_rdata >> NUM_CH) == 32'd0)); // R8

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    AST_HIGH_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_ni)
      clk_o[i] |-> !stopped_v[i]); // R3

    AST_RELEASE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_ni)
      $fell(stopped_v[i]) |-> !clk_o[i]); // R3

    AST_CFG_HELD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_ni)
      (clk_o[i] && $past(clk_o[i])) |->
        ($stable(sel_act_v[i*SEL_W +: SEL_W]) && $stable(div_act_v[i*DIV_W +: DIV_W]))); // R6

    AST_TOGGLE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_ni)
      (clk_o[i] != $past(clk_o[i])) |-> $past(|(src_i ^ src_q))); // R7
  end

endmodule

bind clk_channel_bank clkbank_chk #(
  .NUM_CH (NUM_CH),
  .SEL_W  (SEL_W),
  .DIV_W  (DIV_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_ni    (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wr_en (bus_wr_en),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .src_i     (src_i),
  .src_q     (src_q),
  .stop_q    (stop_q),
  .clk_o     (clk_o),
  .stopped_v (stopped_v),
  .sel_act_v (sel_act_v),
  .div_act_v (div_act_v)
);

// File: tb/clk_channel_bank_tb.sv
module clk_channel_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src = '0;
  logic [15:0] clk_o;

  int n_chk = 0;
  int n_fail = 0;
  int hcnt [4] = '{0, 0, 0, 0};
  int hlen [4] = '{3, 4, 5, 7};

  logic [31:0] sel_sh, div_sh;

  always #4 clk = ~clk;

  clk_channel_bank u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr_en (bus_wr_en),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_i     (src),
    .clk_o     (clk_o)
  );

  // sources: 50% duty, half-periods 3,4,5,7 cycles, changing 2 ns after the edge
  always @(posedge clk) begin
    #2;
    for (int s = 0; s < 4; s++) begin
      if (hcnt[s] == hlen[s] - 1) begin
        src[s] = ~src[s];
        hcnt[s] = 0;
      end else begin
        hcnt[s] = hcnt[s] + 1;
      end
    end
  end

  function automatic int exp_half(input logic [31:0] selw, input logic [31:0] divw, input int ch);
    return hlen[selw[2*ch +: 2]] << divw[2*ch +: 2];
  endfunction

  function automatic logic [31:0] setf(input logic [31:0] w, input int ch, input logic [1:0] v);
    logic [31:0] r;
    r = w;
    r[2*ch +: 2] = v;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(posedge clk); #2;
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_level(input int ch, input bit lvl);
    int g;
    g = 0;
    while (clk_o[ch] !== lvl && g < 3000) begin
      @(negedge clk); g++;
    end
  endtask

  task automatic cnt_level(input int ch, input bit lvl, output int n);
    n = 0;
    while (clk_o[ch] === lvl && n < 3000) begin
      n++; @(negedge clk);
    end
  endtask

  task automatic meas(input int ch, output int hi, output int lo);
    @(negedge clk);
    wait_level(ch, 1'b0);
    wait_level(ch, 1'b1);
    cnt_level(ch, 1'b1, hi);
    cnt_level(ch, 1'b0, lo);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int hi, lo, e;
    int seed_dummy;
    seed_dummy = $urandom(32'h1c0de);

    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2: reset state
    rd(4'h0, d); chk(d == 32'h0000FFFF, "R2 stop reset", d, 32'h0000FFFF);
    rd(4'h4, d); chk(d == 32'h0, "R2 select reset", d, 0);
    rd(4'h8, d); chk(d == 32'h0, "R2 divide reset", d, 0);
    e = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); if (clk_o !== 16'h0) e++;
    end
    chk(e == 0, "R2 outputs low after reset", e, 0);

    // R1 / R8: register access
    wr(4'h4, 32'hA5A51234); rd(4'h4, d); chk(d == 32'hA5A51234, "R1 select readback", d, 32'hA5A51234);
    wr(4'h8, 32'h0F0F3C3C); rd(4'h8, d); chk(d == 32'h0F0F3C3C, "R1 divide readback", d, 32'h0F0F3C3C);
    wr(4'h0, 32'hFFFFFFFF); rd(4'h0, d); chk(d == 32'h0000FFFF, "R8 stop upper bits zero", d, 32'h0000FFFF);
    wr(4'hC, 32'h12345678); rd(4'hC, d); chk(d == 32'h0, "R1 unmapped reads zero", d, 0);
    wr(4'h2, 32'h0);
    rd(4'h4, d); chk(d == 32'hA5A51234, "R1 unmapped write ignored (sel)", d, 32'hA5A51234);
    rd(4'h8, d); chk(d == 32'h0F0F3C3C, "R1 unmapped write ignored (div)", d, 32'h0F0F3C3C);
    rd(4'h0, d); chk(d == 32'h0000FFFF, "R1 unmapped write ignored (stop)", d, 32'h0000FFFF);

    // R7: divide by 1, output toggles one cycle after its source
    sel_sh = '0;
    for (int c = 0; c < 16; c++) sel_sh = setf(sel_sh, c, 2'(c % 4));
    div_sh = '0;
    wr(4'h4, sel_sh); wr(4'h8, div_sh); wr(4'h0, 32'h0);
    repeat (150) @(posedge clk);
    begin
      logic [3:0]  s1, s2;
      logic [15:0] q1;
      int mism [4];
      for (int c = 0; c < 4; c++) mism[c] = 0;
      @(negedge clk); s2 = src; q1 = clk_o;
      @(negedge clk); s1 = src; q1 = clk_o;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        for (int c = 0; c < 4; c++)
          if ((clk_o[c] != q1[c]) != (s1[c] != s2[c])) mism[c]++;
        s2 = s1; s1 = src; q1 = clk_o;
      end
      for (int c = 0; c < 4; c++) chk(mism[c] == 0, "R7 one-cycle toggle", mism[c], 0);
    end

    // R4 / R5: directed extremes then random settings
    for (int r = 0; r < 6; r++) begin
      if (r == 0) begin sel_sh = 32'h0; div_sh = 32'h0; end
      else if (r == 1) begin sel_sh = 32'hFFFFFFFF; div_sh = 32'hFFFFFFFF; end
      else begin sel_sh = $urandom; div_sh = $urandom; end
      wr(4'h4, sel_sh); wr(4'h8, div_sh); wr(4'h0, 32'h0);
      repeat (150) @(posedge clk);
      for (int c = 0; c < 16; c++) begin
        e = exp_half(sel_sh, div_sh, c);
        meas(c, hi, lo);
        chk(hi == e, "R4/R5 high phase length", hi, e);
        chk(lo == e, "R4/R5 low phase length", lo, e);
      end
    end

    // R3: stop during high phase, then release
    sel_sh = setf(32'h0, 5, 2'd0); div_sh = setf(32'h0, 5, 2'd2);
    wr(4'h4, sel_sh); wr(4'h8, div_sh); wr(4'h0, 32'h0);
    repeat (150) @(posedge clk);
    @(negedge clk); wait_level(5, 1'b0); wait_level(5, 1'b1);
    fork
      wr(4'h0, 32'h00000020);
      cnt_level(5, 1'b1, hi);
    join
    chk(hi == 12, "R3 high phase completes on stop", hi, 12);
    e = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk); if (clk_o[5] !== 1'b0) e++;
    end
    chk(e == 0, "R3 stopped channel stays low", e, 0);
    wr(4'h0, 32'h0);
    @(negedge clk); wait_level(5, 1'b1);
    cnt_level(5, 1'b1, hi);
    chk(hi == 12, "R3 first high after release full", hi, 12);

    // R6: divide change while high
    sel_sh = setf(32'h0, 9, 2'd1); div_sh = setf(32'h0, 9, 2'd1);
    wr(4'h4, sel_sh); wr(4'h8, div_sh);
    repeat (150) @(posedge clk);
    @(negedge clk); wait_level(9, 1'b0); wait_level(9, 1'b1);
    div_sh = setf(div_sh, 9, 2'd3);
    fork
      wr(4'h8, div_sh);
      cnt_level(9, 1'b1, hi);
    join
    chk(hi == 8, "R6 current high keeps old divide", hi, 8);
    cnt_level(9, 1'b0, lo);
    chk(lo == 32, "R6 new divide from the fall", lo, 32);
    cnt_level(9, 1'b1, hi);
    chk(hi == 32, "R6 next high uses new divide", hi, 32);

    // R6: select change while high
    @(negedge clk); wait_level(9, 1'b0); wait_level(9, 1'b1);
    sel_sh = setf(sel_sh, 9, 2'd3);
    fork
      wr(4'h4, sel_sh);
      cnt_level(9, 1'b1, hi);
    join
    chk(hi == 32, "R6 current high keeps old source", hi, 32);
    cnt_level(9, 1'b0, lo);
    cnt_level(9, 1'b1, hi);
    chk(hi == 56, "R6 next high uses new source", hi, 56);

    finish_run();
  end

endmodule